// File: doc/BRIEF.md
# Decode-Stage Branch Target Check

This block sits beside the decode stage and checks, within the cycle in which a bundle of decoded instructions arrives, whether the front end guessed the next PC correctly for the instructions whose target is already known. Each lane of the bundle carries a sequence number, a thread id, a PC, three class flags (control, direct, unconditional), the target computed by decode, a predicted-taken bit, the predicted target and a flag that the instruction reads no source registers.

Two cases count as offences. The first is a control transfer that is both direct and unconditional and whose computed target differs from the predicted one. The second is a lane that was predicted taken but is not a control instruction. Lanes are scanned from lane 0, the oldest, and the first offence ends the bundle. Lanes up to and including the offender go downstream, and the offender carries a corrected predicted target. Later lanes are dropped. A squash mask marks every valid lane of the offender's thread whose sequence number is strictly younger. A redirect to fetch is registered on the next clock edge. Three running counters record resolved branches, target mispredictions and control-class errors.

Top module: `dbc_branch_check`

## Requirements
- R1: While reset is held and after it is released, redir_valid is 0 and all three counters read 0.
- R2: A lane is resolvable when it is valid and has is_ctrl, is_direct and is_uncond all set. On each clock edge cnt_resolved grows by the number of resolvable lanes at or before the first offender, or by the number in the whole bundle if no lane offends.
- R3: A resolvable lane whose computed target differs from its predicted target is a target offender. In the next cycle redir_valid is 1 for that cycle, with redir_seq and redir_tid equal to the offender's values, redir_next_pc equal to its computed target, redir_taken 1 and redir_ctrl_err 0. cnt_mispred grows by 1.
- R4: A valid lane with pred_taken 1 and is_ctrl 0 is a control-class offender. The next cycle's redirect carries redir_next_pc equal to its PC plus INST_BYTES (modulo 2^PC_W), redir_taken 0 and redir_ctrl_err 1. cnt_ctrl_err grows by 1. When one lane meets both conditions, this case wins.
- R5: Only the lowest-numbered offending lane produces the redirect. Offences in higher lanes of the same bundle have no effect on the redirect or the counters.
- R6: out_valid is in_valid for lanes at or below the first offender, and 0 for lanes above it. With no offender, out_valid equals in_valid.
- R7: For a target offender, its lane's out_pred_tgt equals its computed target. Every other lane's out_pred_tgt equals its in_pred_tgt.
- R8: Bit i of squash_mask is 1 exactly when an offender exists, lane i is valid, lane i has the offender's thread id, and (seq_i - seq_offender) taken modulo 2^SEQ_W is nonzero with a clear top bit. This comparison stays correct across sequence wraparound.
- R9: out_can_issue equals out_valid AND in_no_src, per lane.
- R10: In the cycle after a bundle with no offender, redir_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | LANES | Lane holds an instruction |
| in_tid | input | LANES*TID_W | Thread id per lane |
| in_seq | input | LANES*SEQ_W | Sequence number per lane |
| in_pc | input | LANES*PC_W | PC per lane |
| in_is_ctrl | input | LANES | Control-transfer instruction |
| in_is_direct | input | LANES | Target encoded in the instruction |
| in_is_uncond | input | LANES | Unconditional transfer |
| in_tgt | input | LANES*PC_W | Target computed at decode |
| in_pred_taken | input | LANES | Front end predicted taken |
| in_pred_tgt | input | LANES*PC_W | Front end predicted target |
| in_no_src | input | LANES | Instruction reads no source registers |
| out_valid | output | LANES | Lane passed downstream this cycle |
| out_pred_tgt | output | LANES*PC_W | Predicted target sent downstream, corrected on offender |
| out_can_issue | output | LANES | Passed lane is ready to issue at once |
| squash_mask | output | LANES | Lanes younger than the offender in its thread |
| redir_valid | output | 1 | One-cycle redirect to fetch |
| redir_tid | output | TID_W | Thread of the redirect |
| redir_seq | output | SEQ_W | Sequence number of the offender |
| redir_next_pc | output | PC_W | PC fetch restarts from |
| redir_taken | output | 1 | Offender is taken |
| redir_ctrl_err | output | 1 | Offence was a non-control predicted taken |
| cnt_resolved | output | CNT_W | Resolved direct unconditional branches |
| cnt_mispred | output | CNT_W | Target mispredictions |
| cnt_ctrl_err | output | CNT_W | Control-class errors |

## Verification
A wrong lane priority or a broken age comparison appears at the ports in the same cycle, as an out_valid, out_pred_tgt or squash_mask bit that disagrees with the arithmetic model. A corrupted redirect register or counter appears one edge later, on the redirect fields or as a counter that drifts from the running total. Once a counter has drifted, every later comparison of that counter fails too. The sweeps use a 4-bit sequence width so that wraparound, mixed threads and reversed lane ages occur often.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    // Kind of offence found in one lane
    typedef enum logic [1:0] {
        OFF_NONE   = 2'd0,
        OFF_TARGET = 2'd1,
        OFF_CTRL   = 2'd2
    } offend_e;

endpackage

// File: rtl/dbc_lane_eval.sv
module dbc_lane_eval
    import dbc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            valid,
    input  logic            is_ctrl,
    input  logic            is_direct,
    input  logic            is_uncond,
    input  logic            pred_taken,
    input  logic [PC_W-1:0] tgt,
    input  logic [PC_W-1:0] pred_tgt,
    output logic            resolvable,
    output offend_e         kind
);

    always_comb begin
        resolvable = valid & is_ctrl & is_direct & is_uncond;
        kind       = OFF_NONE;
        // control-class error takes precedence within a lane
        if (valid && pred_taken && !is_ctrl) begin
            kind = OFF_CTRL;
        end else if (resolvable && (tgt != pred_tgt)) begin
            kind = OFF_TARGET;
        end
    end

endmodule

// File: rtl/dbc_first_pick.sv
module dbc_first_pick #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] hit,
    output logic [LANES-1:0] first_oh,
    output logic [LANES-1:0] keep,
    output logic             any
);

    // seen[i] is set when some lane below i offends
    logic [LANES:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < LANES; g++) begin : g_chain
        assign seen[g+1]   = seen[g] | hit[g];
        assign keep[g]     = ~seen[g];
        assign first_oh[g] = hit[g] & ~seen[g];
    end

    assign any = seen[LANES];

endmodule

// File: rtl/dbc_squash_mask.sv
module dbc_squash_mask #(
    parameter int LANES = 4,
    parameter int SEQ_W = 16,
    parameter int TID_W = 2
) (
    input  logic [LANES-1:0]       valid,
    input  logic [LANES*SEQ_W-1:0] seq,
    input  logic [LANES*TID_W-1:0] tid,
    input  logic                   off_any,
    input  logic [SEQ_W-1:0]       off_seq,
    input  logic [TID_W-1:0]       off_tid,
    output logic [LANES-1:0]       mask
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SEQ_W-1:0] diff;
        logic             younger;
        logic             same_thr;

        // modular difference: positive half of the ring means younger
        assign diff     = seq[g*SEQ_W +: SEQ_W] - off_seq;
        assign younger  = ~diff[SEQ_W-1] & (diff != '0);
        assign same_thr = (tid[g*TID_W +: TID_W] == off_tid);
        assign mask[g]  = off_any & valid[g] & same_thr & younger;
    end

endmodule

// File: rtl/dbc_branch_check.sv
module dbc_branch_check
    import dbc_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int SEQ_W      = 16,
    parameter int PC_W       = 32,
    parameter int TID_W      = 2,
    parameter int CNT_W      = 32,
    parameter int INST_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       in_valid,
    input  logic [LANES*TID_W-1:0] in_tid,
    input  logic [LANES*SEQ_W-1:0] in_seq,
    input  logic [LANES*PC_W-1:0]  in_pc,
    input  logic [LANES-1:0]       in_is_ctrl,
    input  logic [LANES-1:0]       in_is_direct,
    input  logic [LANES-1:0]       in_is_uncond,
    input  logic [LANES*PC_W-1:0]  in_tgt,
    input  logic [LANES-1:0]       in_pred_taken,
    input  logic [LANES*PC_W-1:0]  in_pred_tgt,
    input  logic [LANES-1:0]       in_no_src,
    output logic [LANES-1:0]       out_valid,
    output logic [LANES*PC_W-1:0]  out_pred_tgt,
    output logic [LANES-1:0]       out_can_issue,
    output logic [LANES-1:0]       squash_mask,
    output logic                   redir_valid,
    output logic [TID_W-1:0]       redir_tid,
    output logic [SEQ_W-1:0]       redir_seq,
    output logic [PC_W-1:0]        redir_next_pc,
    output logic                   redir_taken,
    output logic                   redir_ctrl_err,
    output logic [CNT_W-1:0]       cnt_resolved,
    output logic [CNT_W-1:0]       cnt_mispred,
    output logic [CNT_W-1:0]       cnt_ctrl_err
);

    localparam int RES_W = $clog2(LANES + 1);

    typedef struct packed {
        logic             vld;
        logic [TID_W-1:0] tid;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  npc;
        logic             taken;
        logic             cerr;
        logic [CNT_W-1:0] n_res;
        logic [CNT_W-1:0] n_mis;
        logic [CNT_W-1:0] n_cerr;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0] resolvable;
    logic [LANES-1:0] hit;
    offend_e          kind [LANES];
    logic [LANES-1:0] first_oh;
    logic [LANES-1:0] keep;
    logic             off_any;

    // ---------------- per-lane evaluation ----------------
    for (genvar g = 0; g < LANES; g++) begin : g_eval
        dbc_lane_eval #(.PC_W(PC_W)) u_eval (
            .valid      (in_valid[g]),
            .is_ctrl    (in_is_ctrl[g]),
            .is_direct  (in_is_direct[g]),
            .is_uncond  (in_is_uncond[g]),
            .pred_taken (in_pred_taken[g]),
            .tgt        (in_tgt[g*PC_W +: PC_W]),
            .pred_tgt   (in_pred_tgt[g*PC_W +: PC_W]),
            .resolvable (resolvable[g]),
            .kind       (kind[g])
        );
        assign hit[g] = (kind[g] != OFF_NONE);
    end

    // ---------------- oldest offender ----------------
    dbc_first_pick #(.LANES(LANES)) u_pick (
        .hit      (hit),
        .first_oh (first_oh),
        .keep     (keep),
        .any      (off_any)
    );

    // ---------------- offender field select ----------------
    logic [SEQ_W-1:0] off_seq;
    logic [TID_W-1:0] off_tid;
    logic [PC_W-1:0]  off_pc;
    logic [PC_W-1:0]  off_tgt;
    offend_e          off_kind;
    logic [RES_W-1:0] res_cnt;

    always_comb begin
        off_seq  = '0;
        off_tid  = '0;
        off_pc   = '0;
        off_tgt  = '0;
        off_kind = OFF_NONE;
        res_cnt  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (first_oh[i]) begin
                off_seq  = in_seq[i*SEQ_W +: SEQ_W];
                off_tid  = in_tid[i*TID_W +: TID_W];
                off_pc   = in_pc[i*PC_W +: PC_W];
                off_tgt  = in_tgt[i*PC_W +: PC_W];
                off_kind = kind[i];
            end
            res_cnt = res_cnt + RES_W'(keep[i] & resolvable[i]);
        end
    end

    // ---------------- younger-lane squash ----------------
    dbc_squash_mask #(.LANES(LANES), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_mask (
        .valid   (in_valid),
        .seq     (in_seq),
        .tid     (in_tid),
        .off_any (off_any),
        .off_seq (off_seq),
        .off_tid (off_tid),
        .mask    (squash_mask)
    );

    // ---------------- downstream lanes ----------------
    assign out_valid     = in_valid & keep;
    assign out_can_issue = out_valid & in_no_src;

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign out_pred_tgt[g*PC_W +: PC_W] =
            (first_oh[g] && (kind[g] == OFF_TARGET)) ? in_tgt[g*PC_W +: PC_W]
                                                     : in_pred_tgt[g*PC_W +: PC_W];
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d     = st_q;
        st_d.vld = off_any;
        if (off_any) begin
            st_d.tid   = off_tid;
            st_d.seq   = off_seq;
            st_d.npc   = (off_kind == OFF_CTRL) ? off_pc + PC_W'(INST_BYTES) : off_tgt;
            st_d.taken = (off_kind == OFF_TARGET);
            st_d.cerr  = (off_kind == OFF_CTRL);
        end
        st_d.n_res  = st_q.n_res + CNT_W'(res_cnt);
        st_d.n_mis  = st_q.n_mis + CNT_W'(off_kind == OFF_TARGET);
        st_d.n_cerr = st_q.n_cerr + CNT_W'(off_kind == OFF_CTRL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redir_valid    = st_q.vld;
    assign redir_tid      = st_q.tid;
    assign redir_seq      = st_q.seq;
    assign redir_next_pc  = st_q.npc;
    assign redir_taken    = st_q.taken;
    assign redir_ctrl_err = st_q.cerr;
    assign cnt_resolved   = st_q.n_res;
    assign cnt_mispred    = st_q.n_mis;
    assign cnt_ctrl_err   = st_q.n_cerr;

    // ---------------- assertions ----------------
    // R8
    mask_needs_offender_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_mask != '0) |-> off_any);

    // R6
    out_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & ~in_valid) == '0);

    // R3
    redir_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_any |=> redir_valid);

    // R10
    redir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !off_any |=> !redir_valid);

    // R3
    mispred_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mispred != $past(cnt_mispred)) |-> (cnt_mispred == $past(cnt_mispred) + CNT_W'(1)));

    // R4
    ctrl_err_untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && redir_ctrl_err) |-> !redir_taken);

endmodule

// File: tb/dbc_branch_check_tb.sv
module dbc_branch_check_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int SEQ_W      = 4;
    localparam int PC_W       = 8;
    localparam int TID_W      = 1;
    localparam int CNT_W      = 16;
    localparam int INST_BYTES = 4;
    localparam int N_RAND     = 3000;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [LANES-1:0]       in_valid = '0;
    logic [LANES*TID_W-1:0] in_tid = '0;
    logic [LANES*SEQ_W-1:0] in_seq = '0;
    logic [LANES*PC_W-1:0]  in_pc = '0;
    logic [LANES-1:0]       in_is_ctrl = '0;
    logic [LANES-1:0]       in_is_direct = '0;
    logic [LANES-1:0]       in_is_uncond = '0;
    logic [LANES*PC_W-1:0]  in_tgt = '0;
    logic [LANES-1:0]       in_pred_taken = '0;
    logic [LANES*PC_W-1:0]  in_pred_tgt = '0;
    logic [LANES-1:0]       in_no_src = '0;
    logic [LANES-1:0]       out_valid;
    logic [LANES*PC_W-1:0]  out_pred_tgt;
    logic [LANES-1:0]       out_can_issue;
    logic [LANES-1:0]       squash_mask;
    logic                   redir_valid;
    logic [TID_W-1:0]       redir_tid;
    logic [SEQ_W-1:0]       redir_seq;
    logic [PC_W-1:0]        redir_next_pc;
    logic                   redir_taken;
    logic                   redir_ctrl_err;
    logic [CNT_W-1:0]       cnt_resolved;
    logic [CNT_W-1:0]       cnt_mispred;
    logic [CNT_W-1:0]       cnt_ctrl_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbc_branch_check #(
        .LANES(LANES), .SEQ_W(SEQ_W), .PC_W(PC_W), .TID_W(TID_W),
        .CNT_W(CNT_W), .INST_BYTES(INST_BYTES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_tid(in_tid), .in_seq(in_seq), .in_pc(in_pc),
        .in_is_ctrl(in_is_ctrl), .in_is_direct(in_is_direct), .in_is_uncond(in_is_uncond),
        .in_tgt(in_tgt), .in_pred_taken(in_pred_taken), .in_pred_tgt(in_pred_tgt),
        .in_no_src(in_no_src),
        .out_valid(out_valid), .out_pred_tgt(out_pred_tgt), .out_can_issue(out_can_issue),
        .squash_mask(squash_mask),
        .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_seq(redir_seq),
        .redir_next_pc(redir_next_pc), .redir_taken(redir_taken),
        .redir_ctrl_err(redir_ctrl_err),
        .cnt_resolved(cnt_resolved), .cnt_mispred(cnt_mispred), .cnt_ctrl_err(cnt_ctrl_err)
    );

    int total = 0;
    int bad   = 0;

    // bench-side bundle
    logic             b_v    [LANES];
    logic             b_ctrl [LANES];
    logic             b_dir  [LANES];
    logic             b_unc  [LANES];
    logic             b_pt   [LANES];
    logic             b_ns   [LANES];
    logic [TID_W-1:0] b_tid  [LANES];
    logic [SEQ_W-1:0] b_seq  [LANES];
    logic [PC_W-1:0]  b_pc   [LANES];
    logic [PC_W-1:0]  b_tgt  [LANES];
    logic [PC_W-1:0]  b_ptgt [LANES];

    // expected registered state
    logic             e_vld = 1'b0;
    int               e_kind = 0;
    logic [TID_W-1:0] e_tid = '0;
    logic [SEQ_W-1:0] e_seq = '0;
    logic [PC_W-1:0]  e_npc = '0;
    logic [CNT_W-1:0] e_res = '0;
    logic [CNT_W-1:0] e_mis = '0;
    logic [CNT_W-1:0] e_cer = '0;

    logic [31:0] rs = 32'h1234_5678;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic next_rand();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
    endtask

    task automatic set_lane(input int i, input logic v, input logic c, input logic d,
                            input logic u, input logic pt, input logic ns,
                            input logic [TID_W-1:0] t, input logic [SEQ_W-1:0] s,
                            input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tg,
                            input logic [PC_W-1:0] ptg);
        b_v[i] = v; b_ctrl[i] = c; b_dir[i] = d; b_unc[i] = u; b_pt[i] = pt;
        b_ns[i] = ns; b_tid[i] = t; b_seq[i] = s; b_pc[i] = pc; b_tgt[i] = tg;
        b_ptgt[i] = ptg;
    endtask

    task automatic fill_random();
        logic [SEQ_W-1:0] base;
        logic             rev;
        next_rand();
        base = rs[SEQ_W-1:0];
        rev  = rs[8] & rs[9];
        for (int i = 0; i < LANES; i++) begin
            logic [PC_W-1:0] tg;
            next_rand();
            tg = rs[27:20];
            set_lane(i, rs[2:0] != 3'd0, rs[3], rs[4] | rs[5], rs[6] | rs[7],
                     rs[8] & rs[9], rs[10], rs[11],
                     rev ? base + SEQ_W'(LANES-1-i) : base + SEQ_W'(i),
                     rs[19:12], tg,
                     (rs[28] | rs[29]) ? tg : tg ^ PC_W'(1 + rs[31:30]));
        end
    endtask

    // drive one bundle, check same-cycle outputs, then the registered ones
    task automatic run_vec();
        int               off;
        int               kind;
        int               nres;
        logic [LANES-1:0] x_valid;
        logic [LANES-1:0] x_mask;
        logic [LANES-1:0] x_issue;
        for (int i = 0; i < LANES; i++) begin
            in_valid[i]                    = b_v[i];
            in_is_ctrl[i]                  = b_ctrl[i];
            in_is_direct[i]                = b_dir[i];
            in_is_uncond[i]                = b_unc[i];
            in_pred_taken[i]               = b_pt[i];
            in_no_src[i]                   = b_ns[i];
            in_tid[i*TID_W +: TID_W]       = b_tid[i];
            in_seq[i*SEQ_W +: SEQ_W]       = b_seq[i];
            in_pc[i*PC_W +: PC_W]          = b_pc[i];
            in_tgt[i*PC_W +: PC_W]         = b_tgt[i];
            in_pred_tgt[i*PC_W +: PC_W]    = b_ptgt[i];
        end
        #1;
        off = -1; kind = 0; nres = 0;
        for (int i = 0; i < LANES; i++) begin
            if (b_v[i] && off < 0) begin
                bit br;
                br = b_ctrl[i] && b_dir[i] && b_unc[i];
                if (br) nres++;
                if (b_pt[i] && !b_ctrl[i]) begin
                    off = i; kind = 2;
                end else if (br && b_tgt[i] != b_ptgt[i]) begin
                    off = i; kind = 1;
                end
            end
        end
        for (int i = 0; i < LANES; i++) begin
            int d;
            x_valid[i] = b_v[i] && (off < 0 || i <= off);
            x_issue[i] = x_valid[i] && b_ns[i];
            d = (int'(b_seq[i]) - (off >= 0 ? int'(b_seq[off]) : 0)) & ((1 << SEQ_W) - 1);
            x_mask[i] = (off >= 0) && b_v[i] && (b_tid[i] == b_tid[off < 0 ? 0 : off]) &&
                        (d != 0) && (d < (1 << (SEQ_W-1)));
        end
        // R5 R6: lanes above the first offender are dropped
        check(out_valid == x_valid, "R6", "out_valid", out_valid, x_valid);
        // R8: wrap-safe younger mask of the offender's thread
        check(squash_mask == x_mask, "R8", "squash_mask", squash_mask, x_mask);
        // R9
        check(out_can_issue == x_issue, "R9", "out_can_issue", out_can_issue, x_issue);
        for (int i = 0; i < LANES; i++) begin
            logic [PC_W-1:0] xp;
            xp = (i == off && kind == 1) ? b_tgt[i] : b_ptgt[i];
            // R7
            check(out_pred_tgt[i*PC_W +: PC_W] == xp, "R7", "out_pred_tgt",
                  out_pred_tgt[i*PC_W +: PC_W], xp);
        end
        e_vld  = (off >= 0);
        e_kind = kind;
        if (off >= 0) begin
            e_tid = b_tid[off];
            e_seq = b_seq[off];
            e_npc = (kind == 2) ? b_pc[off] + PC_W'(INST_BYTES) : b_tgt[off];
        end
        e_res = e_res + CNT_W'(nres);
        if (kind == 1) e_mis = e_mis + CNT_W'(1);
        if (kind == 2) e_cer = e_cer + CNT_W'(1);
        @(negedge clk);
        if (e_vld) begin
            string rq;
            rq = (e_kind == 2) ? "R4" : "R3";
            check(redir_valid == 1'b1, rq, "redir_valid", redir_valid, 1);
            check(redir_seq == e_seq && redir_tid == e_tid, rq, "redir_seq/tid",
                  {redir_tid, redir_seq}, {e_tid, e_seq});
            check(redir_next_pc == e_npc, rq, "redir_next_pc", redir_next_pc, e_npc);
            check(redir_taken == (e_kind == 1) && redir_ctrl_err == (e_kind == 2), rq,
                  "taken/ctrl_err", {redir_taken, redir_ctrl_err},
                  {e_kind == 1, e_kind == 2});
        end else begin
            // R10
            check(redir_valid == 1'b0, "R10", "redir_valid", redir_valid, 0);
        end
        // R2
        check(cnt_resolved == e_res, "R2", "cnt_resolved", cnt_resolved, e_res);
        // R3 R5
        check(cnt_mispred == e_mis, "R3", "cnt_mispred", cnt_mispred, e_mis);
        // R4 R5
        check(cnt_ctrl_err == e_cer, "R4", "cnt_ctrl_err", cnt_ctrl_err, e_cer);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < LANES; i++) set_lane(i, 0, 0, 0, 0, 0, 0, '0, '0, '0, '0, '0);
        @(negedge clk);
        @(negedge clk);
        // R1 during reset
        check(redir_valid == 1'b0, "R1", "redir_valid in reset", redir_valid, 0);
        check(cnt_resolved == '0 && cnt_mispred == '0 && cnt_ctrl_err == '0, "R1",
              "counters in reset", {cnt_resolved, cnt_mispred, cnt_ctrl_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after release
        check(redir_valid == 1'b0, "R1", "redir_valid after reset", redir_valid, 0);
        check(cnt_resolved == '0, "R1", "cnt_resolved after reset", cnt_resolved, 0);

        // all four lanes resolvable and correct: R2 counts 4, R10 no redirect
        for (int i = 0; i < LANES; i++)
            set_lane(i, 1, 1, 1, 1, 1, 0, 1'b0, SEQ_W'(i), PC_W'(8*i), PC_W'(40+i), PC_W'(40+i));
        run_vec();

        // R3 R8: lane 0 mismatch, sequence wraps 14,15,0,1
        for (int i = 0; i < LANES; i++)
            set_lane(i, 1, 0, 0, 0, 0, 1, 1'b0, SEQ_W'(14 + i), PC_W'(4*i), '0, '0);
        set_lane(0, 1, 1, 1, 1, 1, 0, 1'b0, 4'd14, 8'h10, 8'h80, 8'h84);
        run_vec();

        // R4 R5: lane 1 control error and lane 2 target mismatch, other thread on lane 3
        for (int i = 0; i < LANES; i++)
            set_lane(i, 1, 0, 0, 0, 0, 1, 1'b1, SEQ_W'(5 + i), PC_W'(8'hFC + 4*i), '0, '0);
        set_lane(1, 1, 0, 0, 0, 1, 1, 1'b1, 4'd6, 8'hFE, 8'h00, 8'h00);
        set_lane(2, 1, 1, 1, 1, 1, 0, 1'b1, 4'd7, 8'h02, 8'h20, 8'h30);
        set_lane(3, 1, 0, 0, 0, 0, 0, 1'b0, 4'd8, 8'h04, 8'h00, 8'h00);
        run_vec();

        // idle bundle after an offence: R10
        for (int i = 0; i < LANES; i++) set_lane(i, 0, 0, 0, 0, 1, 1, '0, '0, '0, '0, '0);
        run_vec();

        for (int n = 0; n < N_RAND; n++) begin
            fill_random();
            run_vec();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule